// File: doc/BRIEF.md
# Descriptor-Chain DMA Sequencer

This block walks a chain of two-word descriptors held in system memory and turns each one into an action: hand a buffer address and byte count to an external data mover, skip the line, or jump to another part of the chain. Software points the block at the first descriptor and pulses a start input. The block then reads each descriptor's control word and address word over a simple read port. It decodes the control word and acts on it, one line after another, until a line marked as last completes or a line marked as not valid stops the chain.

The first word of a descriptor is the control word and the second is a byte address. In the control word, bit 0 is the valid flag, bit 1 the last-line flag and bit 2 the line-interrupt flag. Bits 5:4 carry the action code and bits 31:16 the byte count. Bits 3 and 15:6 are ignored. Action 2'b00 skips the line and 2'b01 is handled as a skip. Action 2'b10 moves data and 2'b11 jumps. Three one-cycle interrupt pulses report a line-interrupt, chain completion and an invalid line. The address of the invalid line stays readable after the stop.

Top module: `sg_desc_dma`

## Requirements
- R1: After `rst_n` is released, and in the cycle after a `sw_reset` pulse, `busy`, `rd_req`, `mv_req`, `irq_dma`, `irq_done` and `irq_err` are 0 and `err_addr` is 0.
- R2: When idle, a `start` pulse makes the block read the control word at `start_addr` and then the address word at `start_addr+4`. Each read holds `rd_req` and `rd_addr` until `rd_ack` returns the data on `rd_data`.
- R3: A valid line with action 2'b10 raises `mv_req` with `mv_addr` equal to the address word and `mv_len` equal to the byte count. Both stay stable until `mv_ack`. A byte count of 0 means 65536 bytes.
- R4: A valid line with action 2'b00 or 2'b01 makes no mover request. Its byte count and address are ignored, and the next descriptor is read at the current descriptor address plus 8.
- R5: A valid line with action 2'b11 makes no mover request, and the next descriptor is read at its address word.
- R6: A line whose bit 0 is 0 stops the chain. `irq_err` pulses for one cycle, `busy` falls in that same cycle, `err_addr` holds that line's descriptor address, and no completion pulse is given.
- R7: When a valid line with bit 1 set completes, `irq_done` pulses for one cycle, `busy` falls in that same cycle, and no further descriptor is read.
- R8: When a valid line with bit 2 set completes, `irq_dma` pulses for one cycle and the chain continues. This pulse comes in the same cycle as `irq_done` when bit 1 is also set.
- R9: `sw_reset` returns the block to idle from any state. It drops any descriptor read or mover request in flight, and nothing from the abandoned chain is reported later.
- R10: A `start` pulse while `busy` is 1 is ignored.
- R11: Descriptor addresses are computed modulo 2^ADDR_W, so the line after the one at the top of the address space is read at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_reset | input | 1 | Synchronous software reset back to idle |
| start | input | 1 | Start pulse, accepted only when idle |
| start_addr | input | ADDR_W | Address of the first descriptor |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | ADDR_W | Byte address of the descriptor word being read |
| rd_ack | input | 1 | Read completion; `rd_data` is valid |
| rd_data | input | 32 | Descriptor word returned by memory |
| mv_req | output | 1 | Data mover request |
| mv_addr | output | ADDR_W | Buffer address for the mover |
| mv_len | output | 17 | Byte count for the mover, from 1 to 65536 |
| mv_ack | input | 1 | Mover has finished the request |
| irq_dma | output | 1 | One-cycle line-interrupt pulse |
| irq_done | output | 1 | One-cycle chain-complete pulse |
| irq_err | output | 1 | One-cycle invalid-line pulse |
| busy | output | 1 | Chain is being walked |
| err_addr | output | ADDR_W | Descriptor address of the last invalid line |

## Verification
The bench builds the block with ADDR_W set to 12, which gives a 4 KiB descriptor space. A chain that starts at 0xFF8 then runs across the top of that space and back to address 0, so the R11 wrap is exercised with a small memory model. Descriptor memory answers every other cycle and the mover acknowledges after a few cycles. This leaves room to pulse `sw_reset` and `start` while a read or a move is still pending.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

  localparam int WORD_BYTES = 4;
  localparam int DESC_BYTES = 8;
  localparam int CNT_W      = 16;
  localparam int XLEN_W     = CNT_W + 1;

  typedef enum logic [1:0] {
    ACT_SKIP = 2'b00,
    ACT_RSVD = 2'b01,
    ACT_MOVE = 2'b10,
    ACT_JUMP = 2'b11
  } sgd_act_e;

  // control word, MSB first: count[31:16], spare[15:6], act[5:4], spare[3],
  // irq_en[2], last[1], ok[0]
  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [9:0]       spare_hi;
    sgd_act_e         act;
    logic             spare_lo;
    logic             irq_en;
    logic             last;
    logic             ok;
  } sgd_ctrl_t;

  typedef enum logic [1:0] {
    T_IDLE,
    T_FETCH,
    T_DECODE,
    T_MOVE
  } sgd_state_e;

  typedef enum logic [1:0] {
    F_IDLE,
    F_W0,
    F_W1
  } sgd_fstate_e;

  function automatic sgd_ctrl_t unpack_ctrl(input logic [31:0] w);
    return sgd_ctrl_t'(w);
  endfunction

  // a zero count encodes the full 64 KiB
  function automatic logic [XLEN_W-1:0] xfer_bytes(input logic [CNT_W-1:0] c);
    return (c == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, c};
  endfunction

  function automatic logic [31:0] seq_next(input logic [31:0] a);
    return a + 32'(DESC_BYTES);
  endfunction

endpackage

// File: rtl/sgd_fetch.sv
module sgd_fetch
  import sgd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [31:0]       rd_data,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       addr_q,
  output logic              done
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  sgd_fstate_e       st;
  logic [ADDR_W-1:0] base_q;

  assign rd_req  = (st != F_IDLE);
  assign rd_addr = (st == F_W1) ? base_q + STEP : base_q;
  assign done    = (st == F_W1) && rd_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      base_q <= '0;
      ctrl_q <= '0;
      addr_q <= '0;
    end else if (flush) begin
      st <= F_IDLE;
    end else begin
      case (st)
        F_IDLE: if (go) begin
          base_q <= base;
          st     <= F_W0;
        end
        F_W0: if (rd_ack) begin
          ctrl_q <= rd_data;
          st     <= F_W1;
        end
        F_W1: if (rd_ack) begin
          addr_q <= rd_data;
          st     <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // R2: a pending read keeps its request and address
  a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R9: a flush drops the read in flight
  a_r9_flush_drops_read: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_req);

endmodule

// File: rtl/sgd_decode.sv
module sgd_decode
  import sgd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [31:0]       ctrl_w,
  input  logic [31:0]       addr_w,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              is_bad,
  output logic              is_move,
  output logic              is_last,
  output logic              is_irq,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [XLEN_W-1:0] buf_len
);

  sgd_ctrl_t         c;
  logic [31:0]       cur_ext;
  logic [31:0]       seq_sum;
  logic [ADDR_W-1:0] link_addr;
  logic [ADDR_W-1:0] seq_addr;
  logic              is_jump;
  logic              unused_spare;

  assign c            = unpack_ctrl(ctrl_w);
  assign unused_spare = ^{c.spare_hi, c.spare_lo};

  generate
    if (ADDR_W == 32) begin : g_full
      assign cur_ext   = cur_addr;
      assign link_addr = addr_w;
      assign seq_addr  = seq_sum;
    end else begin : g_narrow
      logic unused_hi;
      assign cur_ext   = {{(32-ADDR_W){1'b0}}, cur_addr};
      assign link_addr = addr_w[ADDR_W-1:0];
      assign seq_addr  = seq_sum[ADDR_W-1:0];
      assign unused_hi = ^{addr_w[31:ADDR_W], seq_sum[31:ADDR_W]};
    end
  endgenerate

  assign seq_sum   = seq_next(cur_ext);
  assign is_bad    = !c.ok;
  assign is_move   = c.ok && (c.act == ACT_MOVE);
  assign is_jump   = c.ok && (c.act == ACT_JUMP);
  assign is_last   = c.last;
  assign is_irq    = c.irq_en;
  assign next_addr = is_jump ? link_addr : seq_addr;
  assign buf_addr  = link_addr;
  assign buf_len   = xfer_bytes(c.count);

endmodule

// File: rtl/sg_desc_dma.sv
module sg_desc_dma
  import sgd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [31:0]       rd_data,
  output logic              mv_req,
  output logic [ADDR_W-1:0] mv_addr,
  output logic [XLEN_W-1:0] mv_len,
  input  logic              mv_ack,
  output logic              irq_dma,
  output logic              irq_done,
  output logic              irq_err,
  output logic              busy,
  output logic [ADDR_W-1:0] err_addr
);

  sgd_state_e        st;
  logic [ADDR_W-1:0] cur_q;
  logic [31:0]       ctrl_w;
  logic [31:0]       addr_w;
  logic              fetch_done;
  logic              fetch_go;
  logic [ADDR_W-1:0] fetch_base;
  logic              is_bad;
  logic              is_move;
  logic              is_last;
  logic              is_irq;
  logic [ADDR_W-1:0] next_addr;

  // named internal events
  logic accept_start;
  logic line_done;
  logic bad_hit;
  logic chain_end;

  assign accept_start = (st == T_IDLE) && start;
  assign bad_hit      = (st == T_DECODE) && is_bad;
  assign line_done    = ((st == T_DECODE) && !is_bad && !is_move) ||
                        ((st == T_MOVE) && mv_ack);
  assign chain_end    = line_done && is_last;
  assign fetch_go     = !sw_reset && (accept_start || (line_done && !is_last));
  assign fetch_base   = (st == T_IDLE) ? start_addr : next_addr;
  assign busy         = (st != T_IDLE);
  assign mv_req       = (st == T_MOVE);

  sgd_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (sw_reset),
    .go      (fetch_go),
    .base    (fetch_base),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .rd_data (rd_data),
    .ctrl_q  (ctrl_w),
    .addr_q  (addr_w),
    .done    (fetch_done)
  );

  sgd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .ctrl_w    (ctrl_w),
    .addr_w    (addr_w),
    .cur_addr  (cur_q),
    .is_bad    (is_bad),
    .is_move   (is_move),
    .is_last   (is_last),
    .is_irq    (is_irq),
    .next_addr (next_addr),
    .buf_addr  (mv_addr),
    .buf_len   (mv_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= T_IDLE;
      cur_q    <= '0;
      err_addr <= '0;
      irq_dma  <= 1'b0;
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
    end else if (sw_reset) begin
      st       <= T_IDLE;
      cur_q    <= '0;
      err_addr <= '0;
      irq_dma  <= 1'b0;
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_dma  <= line_done && is_irq;
      irq_done <= chain_end;
      irq_err  <= bad_hit;
      case (st)
        T_IDLE: if (accept_start) begin
          cur_q <= start_addr;
          st    <= T_FETCH;
        end
        T_FETCH: if (fetch_done) st <= T_DECODE;
        T_DECODE: begin
          if (is_bad) begin
            err_addr <= cur_q;
            st       <= T_IDLE;
          end else if (is_move) begin
            st <= T_MOVE;
          end
        end
        T_MOVE: ;
        default: st <= T_IDLE;
      endcase
      if (line_done) begin
        if (is_last) begin
          st <= T_IDLE;
        end else begin
          cur_q <= next_addr;
          st    <= T_FETCH;
        end
      end
    end
  end

  // R1: nothing is requested while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !mv_req));

  // R3: the mover request stays stable until it is acknowledged
  a_r3_move_hold: assert property (@(posedge clk) disable iff (!rst_n || sw_reset)
    (mv_req && !mv_ack) |=> (mv_req && $stable(mv_addr) && $stable(mv_len)));

  // R3: the byte count handed to the mover lies between 1 and 65536
  a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |-> ((mv_len != '0) && (mv_len <= XLEN_W'(65536))));

  // R6: an invalid line stops the chain without a completion pulse
  a_r6_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (!busy && !irq_done));

  // R7: completion leaves the block idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> !busy);

  // R8: a line interrupt lasts a single cycle
  a_r8_dma_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dma |=> !irq_dma);

  // R9: a software reset leaves the block idle and silent
  a_r9_sw_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (!busy && !irq_dma && !irq_done && !irq_err));

endmodule

// File: tb/sim_sg_desc_dma.sv
`timescale 1ns/1ps
module sim_sg_desc_dma;

  localparam int AW = 12;

  typedef enum int {K_MOVE, K_DMA, K_DONE, K_ERR} kind_e;
  typedef struct {
    kind_e      kind;
    logic [31:0] addr;
    logic [31:0] len;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_reset = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack = 1'b0;
  logic [31:0]   rd_data = '0;
  logic          mv_req;
  logic [AW-1:0] mv_addr;
  logic [16:0]   mv_len;
  logic          mv_ack = 1'b0;
  logic          irq_dma, irq_done, irq_err, busy;
  logic [AW-1:0] err_addr;

  logic [31:0] mem [1024];
  item_t       q[$];
  int          checks = 0;
  int          fails = 0;
  int          mv_cnt = 0;
  bit          mv_seen = 0;
  bit          mv_hold = 0;
  int          cycles = 0;

  always #2 clk = ~clk;

  sg_desc_dma #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .start(start),
    .start_addr(start_addr), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .mv_req(mv_req), .mv_addr(mv_addr),
    .mv_len(mv_len), .mv_ack(mv_ack), .irq_dma(irq_dma), .irq_done(irq_done),
    .irq_err(irq_err), .busy(busy), .err_addr(err_addr)
  );

  // control word: count[31:16], action[5:4], irq[2], last[1], valid[0]
  function automatic logic [31:0] mk(input int cnt, input int act,
                                     input bit ie, input bit last, input bit ok);
    return {cnt[15:0], 10'b0, act[1:0], 1'b0, ie, last, ok};
  endfunction

  task automatic put(input int a, input logic [31:0] cw, input logic [31:0] aw);
    mem[(a >> 2) & 1023]       = cw;
    mem[((a + 4) >> 2) & 1023] = aw;
  endtask

  task automatic expect_ev(input kind_e k, input int a, input int l);
    item_t it;
    it.kind = k; it.addr = a; it.len = l;
    q.push_back(it);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input kind_e k);
    case (k)
      K_MOVE: return "R3";
      K_DMA:  return "R8";
      K_DONE: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic got(input kind_e k, input int a, input int l);
    item_t it;
    if (q.size() == 0) begin
      chk(1'b0, req_of(k), "unexpected event kind", int'(k), -1);
    end else begin
      it = q.pop_front();
      chk(it.kind == k, req_of(it.kind), "event kind", int'(k), int'(it.kind));
      chk(it.addr == a && it.len == l, req_of(it.kind), "event addr/len",
          a * 65536 * 2 + l, it.addr * 65536 * 2 + it.len);
    end
  endtask

  // descriptor memory: answers every other cycle
  always @(negedge clk) begin
    rd_ack  = rd_req && !rd_ack;
    rd_data = mem[rd_addr[11:2]];
  end

  // monitor and mover model
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_dma)  got(K_DMA, 0, 0);
      if (irq_done) got(K_DONE, 0, 0);
      if (irq_err)  got(K_ERR, int'(err_addr), 0);
      if (mv_req) begin
        if (!mv_seen) begin
          mv_seen = 1;
          mv_cnt  = 2;
          got(K_MOVE, int'(mv_addr), int'(mv_len));
        end else if (!mv_hold) begin
          if (mv_cnt > 0) mv_cnt--;
          else mv_ack = 1'b1;
        end
      end else begin
        mv_ack  = 1'b0;
        mv_seen = 0;
      end
    end
  end

  task automatic kick(input int a);
    @(negedge clk);
    start_addr = a[AW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while ((busy || q.size() != 0) && n < 3000);
    chk(n < 3000, req, "watchdog chain finish", n, 3000);
    repeat (3) @(posedge clk);
    #1;
    chk(q.size() == 0, req, "pending expected events", q.size(), 0);
    q.delete();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !rd_req && !mv_req, "R1", "idle after reset",
        {busy, rd_req, mv_req}, 0);
    chk(!irq_dma && !irq_done && !irq_err, "R1", "irqs after reset",
        {irq_dma, irq_done, irq_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_addr == 0 && !busy, "R1", "err_addr after reset", err_addr, 0);

    // R2 R3 R4 R8 R7: move with irq, skip, reserved skip, full-size move ending
    put(32'h100, mk(64, 2, 1, 0, 1), 32'h800);
    put(32'h108, mk(16'h1234, 0, 0, 0, 1), 32'h0);
    put(32'h110, mk(7, 1, 0, 0, 1), 32'h3);
    put(32'h118, mk(0, 2, 0, 1, 1), 32'h900);
    expect_ev(K_MOVE, 32'h800, 64);
    expect_ev(K_DMA, 0, 0);
    expect_ev(K_MOVE, 32'h900, 65536);
    expect_ev(K_DONE, 0, 0);
    kick(32'h100);
    wait_idle("R4");
    chk(!busy, "R7", "busy after completion", busy, 0);

    // R5: jump over a poisoned line
    put(32'h200, mk(0, 3, 0, 0, 1), 32'h340);
    put(32'h208, mk(0, 0, 0, 0, 0), 32'h0);
    put(32'h340, mk(12, 2, 1, 1, 1), 32'hA00);
    expect_ev(K_MOVE, 32'hA00, 12);
    expect_ev(K_DMA, 0, 0);
    expect_ev(K_DONE, 0, 0);
    kick(32'h200);
    wait_idle("R5");

    // R6: invalid second line
    put(32'h400, mk(0, 0, 0, 0, 1), 32'h0);
    put(32'h408, mk(5, 2, 0, 1, 0), 32'h123);
    expect_ev(K_ERR, 32'h408, 0);
    kick(32'h400);
    wait_idle("R6");
    chk(err_addr == 12'h408, "R6", "err_addr held", err_addr, 32'h408);
    chk(!busy, "R6", "busy after error", busy, 0);

    // R11: wrap from top of address space to zero
    put(32'hFF8, mk(0, 0, 0, 0, 1), 32'h0);
    put(32'h000, mk(4, 2, 0, 1, 1), 32'h40);
    expect_ev(K_MOVE, 32'h40, 4);
    expect_ev(K_DONE, 0, 0);
    kick(32'hFF8);
    wait_idle("R11");
    chk(err_addr == 12'h408, "R6", "err_addr kept across chains", err_addr, 32'h408);

    // R9: reset during descriptor fetch; chain at 0x400 would error
    kick(32'h400);
    @(negedge clk);
    sw_reset = 1'b1;
    @(negedge clk);
    sw_reset = 1'b0;
    chk(!busy && !rd_req, "R9", "idle after reset in fetch", {busy, rd_req}, 0);
    chk(err_addr == 0, "R9", "err_addr cleared by sw_reset", err_addr, 0);
    wait_idle("R9");

    // R9: reset while a move is pending
    put(32'h500, mk(32, 2, 1, 1, 1), 32'hB00);
    expect_ev(K_MOVE, 32'hB00, 32);
    mv_hold = 1;
    kick(32'h500);
    repeat (12) @(negedge clk);
    chk(mv_req == 1'b1, "R9", "move pending before reset", mv_req, 1);
    sw_reset = 1'b1;
    @(negedge clk);
    sw_reset = 1'b0;
    mv_hold = 0;
    chk(!busy && !mv_req, "R9", "idle after reset in move", {busy, mv_req}, 0);
    put(32'h600, mk(0, 0, 0, 1, 1), 32'h0);
    expect_ev(K_DONE, 0, 0);
    kick(32'h600);
    wait_idle("R9");

    // R10: start while busy is ignored
    put(32'h700, mk(20, 2, 0, 1, 1), 32'h100);
    expect_ev(K_MOVE, 32'h100, 20);
    expect_ev(K_DONE, 0, 0);
    kick(32'h700);
    @(negedge clk);
    start_addr = 12'h400;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle("R10");
    chk(err_addr == 0, "R10", "no error from ignored start", err_addr, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule